// File: doc/BRIEF.md
# Exact Posit Dot-Product Accumulator

This block builds dot products of small posit numbers without rounding. It holds a wide two's complement fixed-point register, the quire. Each accepted command multiplies two posit operands exactly and adds the full product into that register. Both operands are decoded inside the block: the sign, the run-length regime, up to ES exponent bits and the fraction, with missing exponent and fraction bits read as zero. The product significand is aligned by the sum of the two operand scales and added in one cycle. Nothing is rounded at any step.

A clear command sets the register to zero before a new dot product starts. Software-visible output is the raw register contents, a flag that reports the not-a-real (NaR) state, and a one-cycle done pulse for each accepted operand pair. Turning the quire back into a rounded posit is left to other logic.

Top module: `quire_mac`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `quire_o` is zero and `nar_o` and `done_o` are low.
- R2: The quire is 16*N bits wide and counts in units of the square of the smallest positive posit. The product 1.0 x 1.0 (operands 0x40, 0x40) therefore sets exactly bit 2*(N-2)*2^ES, which is bit 48 for the default N=8, ES=2.
- R3: Operands decode with a regime scale of 2^ES per regime step. 0x01 x 0x01 adds exactly 1, and 0x7F x 0x7F (scale +24 each) adds exactly 2^96.
- R4: When the operand signs differ, the product is subtracted as a two's complement value. A negative operand is the two's complement of its positive code, so 0xC0 means -1.0.
- R5: An accepted pair with a zero operand (code 0x00) leaves the quire unchanged. `done_o` still pulses.
- R6: An accepted pair with a NaR operand (code 0x80) sets the quire to the reserved pattern, which is bit 16*N-1 set and all other bits clear. `nar_o` goes high.
- R7: Once the quire holds the NaR pattern, it keeps that pattern through later accumulations until a clear.
- R8: A clear (`clr_i` high at a clock edge) sets the quire to zero. This also leaves the NaR state.
- R9: When `clr_i` and `acc_valid_i` are high in the same cycle, the clear wins: the operand pair is dropped and `done_o` stays low on the next cycle.
- R10: `done_o` is high for exactly the one cycle after the edge that accepts a pair. In that same cycle `quire_o` already shows the updated sum.
- R11: Over any sequence of accepted non-NaR pairs, `quire_o` equals the exact integer sum of the products. A product followed by its negation returns the quire to its prior value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clear the quire to zero |
| acc_valid_i | input | 1 | Accumulate the product of `opa_i` and `opb_i` |
| opa_i | input | N | First posit operand |
| opb_i | input | N | Second posit operand |
| quire_o | output | 16*N | Raw two's complement quire contents |
| nar_o | output | 1 | Quire holds the NaR pattern |
| done_o | output | 1 | One-cycle pulse after an accepted pair |

## Verification
The bench builds the block with its default parameters: N=8 and ES=2, which gives a 128-bit quire. At this size every one of the 256 operand codes can be reached. This includes both extremes of the product range: the square of the smallest posit lands on bit 0, and the square of the largest lands on bit 96. The reference decodes each operand by scanning its bits one at a time. It forms each product as a 128-bit integer, so long random runs with mixed signs, zeros and extreme regimes can be compared bit for bit. NaR entry, stickiness, clear priority and the done timing are covered by directed scenarios.

// File: rtl/quire_pkg.sv
package quire_pkg;

  // Length of the run of identical bits starting at bit 63 of v,
  // limited to the top len bits.
  function automatic int lead_run(input logic [63:0] v, input int len);
    int   cnt;
    logic go;
    cnt = 0;
    go  = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (i < len) begin
        if (go && (v[63-i] == v[63])) cnt++;
        else go = 1'b0;
      end
    end
    return cnt;
  endfunction

endpackage

// File: rtl/quire_operand_decode.sv
module quire_operand_decode #(
  parameter int N  = 8,
  parameter int ES = 2,
  parameter int SW = 7,
  parameter int FW = N - 3 - ES,
  parameter int RW = $clog2(N) + 1
) (
  input  logic [N-1:0]         posit_i,
  output logic                 nar_o,
  output logic                 zero_o,
  output logic                 sign_o,
  output logic signed [SW-1:0] scale_o,
  output logic [FW:0]          sig_o
);
  logic [N-1:0]         mag;
  logic [N-2:0]         body;
  logic [RW-1:0]        run;
  logic signed [SW-1:0] k;
  logic [ES+FW-1:0]     tail;
  logic [ES-1:0]        ex;

  always_comb begin
    mag  = posit_i[N-1] ? (~posit_i + 1'b1) : posit_i;
    body = mag[N-2:0];
    run  = RW'(quire_pkg::lead_run({body, {(65-N){1'b0}}}, N - 1));
    k    = body[N-2] ? ($signed(SW'(run)) - SW'(1)) : -$signed(SW'(run));
    // bits following the shortest legal regime, realigned after the real one
    tail = body[N-4:0] << (run - RW'(1));
    ex   = tail[ES+FW-1:FW];
    sig_o   = {1'b1, tail[FW-1:0]};
    scale_o = (k <<< ES) + $signed(SW'(ex));
    nar_o   = mag[N-1];
    zero_o  = ~|posit_i;
    sign_o  = posit_i[N-1];
  end
endmodule

// File: rtl/quire_product_align.sv
module quire_product_align #(
  parameter int N  = 8,
  parameter int ES = 2,
  parameter int SW = 7,
  parameter int FW = N - 3 - ES,
  parameter int QW = 16 * N
) (
  input  logic                 sign_a_i,
  input  logic                 sign_b_i,
  input  logic signed [SW-1:0] scale_a_i,
  input  logic signed [SW-1:0] scale_b_i,
  input  logic [FW:0]          sig_a_i,
  input  logic [FW:0]          sig_b_i,
  output logic [QW-1:0]        addend_o
);
  localparam int MAXSC = (N - 2) * (1 << ES);
  localparam int SHW   = $clog2(4 * MAXSC + 1);
  localparam int PW    = 2 * FW + 2;

  logic [PW-1:0]        prod;
  logic signed [SW+1:0] sh_s;
  logic [SHW-1:0]       sh;
  logic [QW-1:0]        mag;

  always_comb begin
    prod = PW'(sig_a_i) * PW'(sig_b_i);
    sh_s = (SW+2)'(scale_a_i) + (SW+2)'(scale_b_i) + (SW+2)'(2 * MAXSC);
    sh   = SHW'(sh_s);
    // product carries 2*FW fraction bits; dropped bits are always zero
    if (sh >= SHW'(2 * FW)) mag = QW'(prod) << (sh - SHW'(2 * FW));
    else                    mag = QW'(prod) >> (SHW'(2 * FW) - sh);
    addend_o = (sign_a_i ^ sign_b_i) ? (~mag + 1'b1) : mag;
  end
endmodule

// File: rtl/quire_acc_reg.sv
module quire_acc_reg #(
  parameter int QW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          accept_i,
  input  logic          nar_in_i,
  input  logic          skip_i,
  input  logic [QW-1:0] addend_i,
  output logic [QW-1:0] quire_o,
  output logic          done_o
);
  localparam logic [QW-1:0] NAR_PAT = {1'b1, {(QW-1){1'b0}}};

  logic held_nar;
  assign held_nar = (quire_o == NAR_PAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quire_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= accept_i;
      if (clr_i)                       quire_o <= '0;
      else if (accept_i) begin
        if (held_nar || nar_in_i)      quire_o <= NAR_PAT;
        else if (!skip_i)              quire_o <= quire_o + addend_i;
      end
    end
  end
endmodule

// File: rtl/quire_mac.sv
module quire_mac #(
  parameter int N  = 8,
  parameter int ES = 2,
  parameter int QW = 16 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          acc_valid_i,
  input  logic [N-1:0]  opa_i,
  input  logic [N-1:0]  opb_i,
  output logic [QW-1:0] quire_o,
  output logic          nar_o,
  output logic          done_o
);
  localparam int FW    = N - 3 - ES;
  localparam int MAXSC = (N - 2) * (1 << ES);
  localparam int SW    = $clog2(MAXSC + 1) + 2;

  logic [1:0][N-1:0]         ops;
  logic [1:0]                op_nar, op_zero, op_sign;
  logic signed [SW-1:0]      op_scale [2];
  logic [FW:0]               op_sig   [2];
  logic [QW-1:0]             addend_w;
  logic                      accept_w, nar_in_w, skip_w;

  assign ops = {opb_i, opa_i};

  for (genvar g = 0; g < 2; g++) begin : g_dec
    quire_operand_decode #(.N(N), .ES(ES), .SW(SW), .FW(FW)) u_dec (
      .posit_i (ops[g]),
      .nar_o   (op_nar[g]),
      .zero_o  (op_zero[g]),
      .sign_o  (op_sign[g]),
      .scale_o (op_scale[g]),
      .sig_o   (op_sig[g])
    );
  end

  quire_product_align #(.N(N), .ES(ES), .SW(SW), .FW(FW), .QW(QW)) u_align (
    .sign_a_i  (op_sign[0]),
    .sign_b_i  (op_sign[1]),
    .scale_a_i (op_scale[0]),
    .scale_b_i (op_scale[1]),
    .sig_a_i   (op_sig[0]),
    .sig_b_i   (op_sig[1]),
    .addend_o  (addend_w)
  );

  assign accept_w = acc_valid_i & ~clr_i;
  assign nar_in_w = |op_nar;
  assign skip_w   = |op_zero;

  quire_acc_reg #(.QW(QW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .accept_i (accept_w),
    .nar_in_i (nar_in_w),
    .skip_i   (skip_w),
    .addend_i (addend_w),
    .quire_o  (quire_o),
    .done_o   (done_o)
  );

  assign nar_o = quire_o[QW-1] & ~|quire_o[QW-2:0];
endmodule

// File: rtl/quire_mac_chk.sv
module quire_mac_chk #(
  parameter int N  = 8,
  parameter int QW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_i,
  input logic          acc_valid_i,
  input logic [N-1:0]  opa_i,
  input logic [N-1:0]  opb_i,
  input logic [QW-1:0] quire_o,
  input logic          nar_o,
  input logic          done_o,
  input logic          accept_w,
  input logic          nar_in_w
);
  localparam logic [N-1:0] NAR_CODE = {1'b1, {(N-1){1'b0}}};

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (quire_o == '0));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !done_o);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> done_o);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid_i && !clr_i) |=> !done_o);

  assert_zero_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !nar_o && opa_i != NAR_CODE && opb_i != NAR_CODE &&
     (opa_i == '0 || opb_i == '0)) |=> $stable(quire_o));

  assert_nar_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !clr_i && (opa_i == NAR_CODE || opb_i == NAR_CODE)) |=> nar_o);

  assert_nar_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && nar_in_w) |=> (quire_o[QW-1] && $countones(quire_o) == 1));

  assert_nar_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nar_o && !clr_i) |=> nar_o);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid_i && !clr_i) |=> $stable(quire_o));
endmodule

bind quire_mac quire_mac_chk #(.N(N), .QW(QW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .acc_valid_i (acc_valid_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .quire_o     (quire_o),
  .nar_o       (nar_o),
  .done_o      (done_o),
  .accept_w    (accept_w),
  .nar_in_w    (nar_in_w)
);

// File: tb/quire_mac_tb.sv
module quire_mac_tb;
  localparam int N     = 8;
  localparam int ES    = 2;
  localparam int FW    = N - 3 - ES;
  localparam int QW    = 16 * N;
  localparam int MAXSC = (N - 2) * (1 << ES);
  localparam logic [QW-1:0] NAR_Q = {1'b1, {(QW-1){1'b0}}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_i = 1'b0;
  logic          acc_valid_i = 1'b0;
  logic [N-1:0]  opa_i = '0;
  logic [N-1:0]  opb_i = '0;
  logic [QW-1:0] quire_o;
  logic          nar_o;
  logic          done_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;
  logic signed [QW-1:0] model = '0;

  always #4 clk = ~clk;

  quire_mac #(.N(N), .ES(ES), .QW(QW)) u_dut (
    .clk (clk), .rst_n (rst_n), .clr_i (clr_i), .acc_valid_i (acc_valid_i),
    .opa_i (opa_i), .opb_i (opb_i), .quire_o (quire_o), .nar_o (nar_o), .done_o (done_o)
  );

  // value of a posit in units of the smallest positive posit, found bit by bit
  function automatic longint units(input logic [N-1:0] p);
    logic [N-1:0] m;
    int i, run, k, e, f, sc, sh;
    longint sig, u;
    if (p == '0) return 0;
    m = p[N-1] ? N'(-p) : p;
    i = N - 2; run = 0;
    while (i >= 0 && m[i] == m[N-2]) begin run++; i--; end
    i--;
    e = 0;
    repeat (ES) begin e = e * 2 + ((i >= 0) ? int'(m[i]) : 0); i--; end
    f = 0;
    repeat (FW) begin f = f * 2 + ((i >= 0) ? int'(m[i]) : 0); i--; end
    k   = m[N-2] ? run - 1 : -run;
    sc  = k * (1 << ES) + e;
    sig = longint'((1 << FW) + f);
    sh  = sc + MAXSC - FW;
    u   = (sh >= 0) ? (sig <<< sh) : (sig >>> (-sh));
    return p[N-1] ? -u : u;
  endfunction

  function automatic logic signed [QW-1:0] exact_prod(input logic [N-1:0] a, input logic [N-1:0] b);
    logic signed [QW-1:0] wa, wb;
    wa = units(a);
    wb = units(b);
    return wa * wb;
  endfunction

  task automatic chk(input string req, input logic [QW-1:0] got, input logic [QW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic acc(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    acc_valid_i = 1'b1; opa_i = a; opb_i = b;
    @(negedge clk);
    acc_valid_i = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    model = '0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 quire in reset", quire_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 quire after reset", quire_o, '0);
    chk("R1 nar after reset", QW'(nar_o), '0);
    chk("R1 done after reset", QW'(done_o), '0);
  endtask

  task automatic t_weights();
    clear();
    acc(8'h40, 8'h40);
    chk("R2 one times one", quire_o, QW'(1) << (2 * MAXSC));
    clear();
    acc(8'h01, 8'h01);
    chk("R3 minpos squared", quire_o, QW'(1));
    clear();
    acc(8'h7F, 8'h7F);
    chk("R3 maxpos squared", quire_o, QW'(1) << (4 * MAXSC));
    clear();
    acc(8'h48, 8'h50);
    chk("R3 mid regime codes", quire_o, exact_prod(8'h48, 8'h50));
  endtask

  task automatic t_sign();
    clear();
    acc(8'hC0, 8'h40);
    chk("R4 minus one", quire_o, -(QW'(1) << (2 * MAXSC)));
    acc(8'hC0, 8'hC0);
    chk("R4 two negatives cancel", quire_o, '0);
    acc(8'h33, 8'hB7);
    chk("R4 mixed signs", quire_o, exact_prod(8'h33, 8'hB7));
  endtask

  task automatic t_zero();
    clear();
    acc(8'h5A, 8'h21);
    model = exact_prod(8'h5A, 8'h21);
    @(negedge clk);
    acc_valid_i = 1'b1; opa_i = 8'h00; opb_i = 8'h7F;
    @(negedge clk);
    acc_valid_i = 1'b0;
    chk("R5 zero operand done", QW'(done_o), QW'(1));
    chk("R5 zero operand no change", quire_o, model);
    acc(8'hE3, 8'h00);
    chk("R5 zero second operand", quire_o, model);
  endtask

  task automatic t_nar();
    clear();
    acc(8'h44, 8'h44);
    acc(8'h80, 8'h40);
    chk("R6 nar pattern", quire_o, NAR_Q);
    chk("R6 nar flag", QW'(nar_o), QW'(1));
    acc(8'h7F, 8'h7F);
    chk("R7 sticky after product", quire_o, NAR_Q);
    acc(8'h00, 8'h12);
    chk("R7 sticky after zero", quire_o, NAR_Q);
    clear();
    chk("R8 clear leaves nar", quire_o, '0);
    chk("R8 nar flag low", QW'(nar_o), '0);
    acc(8'h40, 8'h80);
    chk("R6 nar second operand", QW'(nar_o), QW'(1));
    clear();
  endtask

  task automatic t_done();
    clear();
    @(negedge clk);
    acc_valid_i = 1'b1; opa_i = 8'h40; opb_i = 8'h40;
    @(negedge clk);
    acc_valid_i = 1'b0;
    chk("R10 done pulse", QW'(done_o), QW'(1));
    chk("R10 sum visible with done", quire_o, QW'(1) << (2 * MAXSC));
    @(negedge clk);
    chk("R10 done single cycle", QW'(done_o), '0);
  endtask

  task automatic t_clr_prio();
    clear();
    acc(8'h40, 8'h40);
    @(negedge clk);
    clr_i = 1'b1; acc_valid_i = 1'b1; opa_i = 8'h7F; opb_i = 8'h7F;
    @(negedge clk);
    clr_i = 1'b0; acc_valid_i = 1'b0;
    chk("R9 clear wins quire", quire_o, '0);
    chk("R9 no done on clear", QW'(done_o), '0);
  endtask

  task automatic t_cancel();
    clear();
    acc(8'h40, 8'h40);
    model = exact_prod(8'h40, 8'h40);
    acc(8'h6D, 8'h19);
    acc(8'h93, 8'h19);
    chk("R11 product and negation", quire_o, model);
  endtask

  task automatic t_random();
    logic [N-1:0] a, b;
    clear();
    for (int n = 0; n < 400; n++) begin
      a = N'($urandom);
      b = N'($urandom);
      if (a == 8'h80) a = 8'h81;
      if (b == 8'h80) b = 8'h7F;
      if (n % 37 == 5) a = 8'h00;
      acc(a, b);
      model = model + exact_prod(a, b);
      chk("R11 running exact sum", quire_o, model);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_weights();
    t_sign();
    t_zero();
    t_nar();
    t_done();
    t_clr_prio();
    t_cancel();
    t_random();
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule